// File: doc/BRIEF.md
# ACPI Event Status and SCI Aggregator

This block keeps the power-management event state of a chipset: a 16-bit fixed-event status register and its enable register, a four-byte general-purpose event window, and the SCI enable flag. Single-cycle event pulses set status bits. Software clears them by writing ones. The block combines the enabled, pending events into one level-sensitive system control interrupt (SCI).

A separate byte-wide APM command path decodes the firmware handshake codes. These codes switch the SCI enable flag on or off. Any APM command can also raise a one-cycle SMI pulse.

Register access uses byte-wide, single-cycle writes and combinational reads on a 4-bit byte address. The map is:

| Address | Contents |
|---|---|
| 0–1 | fixed status, low byte first |
| 2–3 | fixed enable, low byte first |
| 4 | SCI enable flag in bit 0 (read-only) |
| 5 | reads zero |
| 8–9 | GPE status bytes |
| 10–11 | GPE enable bytes |

Top module: `acpi_sci_agg`

## Requirements
- R1: After reset, all status bytes, enable bytes and the SCI enable flag read zero, and sci_o, smi_o and tmr_arm_o are low.
- R2: The fixed registers implement only these bits: bit 0 is timer, bit 5 is global lock, bit 8 is power button and bit 10 is RTC. Every other bit reads zero, and writes to it are ignored.
- R3: Writing a 1 to a status bit clears it. Writing a 0 leaves that bit unchanged.
- R4: If an event pulse sets a status bit in the same cycle that software writes a 1 to clear it, the bit ends up set.
- R5: sci_o is high whenever any of the four fixed bits is both pending and enabled.
- R6: sci_o is also high when GPE status byte 0 bit 1 (the hotplug bit, set by hotplug_evt_i) is pending and GPE enable byte 0 bit 1 is set. No other GPE bit affects sci_o. GPE enable bytes are fully writable and read back at addresses 10 and 11.
- R7: sci_o reflects a register write or an event in the cycle after the clock edge that captured it.
- R8: tmr_arm_o is high exactly when the timer enable bit is set and the timer status bit is clear.
- R9: An APM command of 0xF1 sets the SCI enable flag (address 4, bit 0). A command of 0xF0 clears it. Any other command leaves it unchanged.
- R10: Every APM command produces a one-cycle smi_o pulse in the following cycle when smi_cfg_i is high. No pulse is produced when smi_cfg_i is low.
- R11: A power-down request pulse on pwrbtn_evt_i sets the power-button status bit (address 1, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| tmr_evt_i | input | 1 | Timer overflow pulse |
| gbl_evt_i | input | 1 | Global lock release pulse |
| pwrbtn_evt_i | input | 1 | Power button or power-down request pulse |
| rtc_evt_i | input | 1 | RTC alarm pulse |
| hotplug_evt_i | input | 1 | PCI hotplug event pulse |
| apm_we_i | input | 1 | APM command write strobe |
| apm_cmd_i | input | 8 | APM command byte |
| smi_cfg_i | input | 1 | SMI generation allowed |
| sci_o | output | 1 | SCI level |
| smi_o | output | 1 | SMI pulse |
| tmr_arm_o | output | 1 | Request to arm the overflow timer |

## Verification
The bench targets a clear write and an event pulse that arrive in the same cycle. A design that gave the clear priority would lose that event, and the status byte would read zero.

It checks that the SCI ignores GPE enable bits other than the hotplug bit. A design that ORed the whole GPE byte would raise sci_o when it should stay low.

It checks that writes to unimplemented fixed bits read back as zero. A masking error would echo 0xFF instead.

It sends an APM command other than the two handshake codes. A decoder that compared too few bits would toggle the SCI enable flag.

It also checks that the SMI pulse lasts exactly one cycle, and that no pulse appears while smi_cfg_i is low.

// File: rtl/acpi_evt_pkg.sv
package acpi_evt_pkg;
  localparam int PM1_TMR    = 0;
  localparam int PM1_GBL    = 5;
  localparam int PM1_PWRBTN = 8;
  localparam int PM1_RTC    = 10;
  localparam logic [15:0] PM1_IMPL = 16'h0521;
  localparam logic [7:0]  APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0]  APM_ACPI_OFF = 8'hF0;
  localparam int GPE_HP_BIT = 1;

  typedef struct packed {
    logic tmr;
    logic gbl;
    logic pwrbtn;
    logic rtc;
  } pm1_evt_t;
endpackage

// File: rtl/acpi_pm1_regs.sv
module acpi_pm1_regs
  import acpi_evt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_W    = 16,
  parameter int STS_BASE = 0,
  parameter int EN_BASE  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  pm1_evt_t         evt_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o
);
  localparam int LANES = REG_W / 8;

  logic [REG_W-1:0] set_v;

  always_comb begin
    set_v = '0;
    set_v[PM1_TMR]    = evt_i.tmr;
    set_v[PM1_GBL]    = evt_i.gbl;
    set_v[PM1_PWRBTN] = evt_i.pwrbtn;
    set_v[PM1_RTC]    = evt_i.rtc;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic       sts_hit, en_hit;
    logic [7:0] sts_q, en_q, impl;
    assign impl    = PM1_IMPL[b*8 +: 8];
    assign sts_hit = wr_en_i && (wr_addr_i == ADDR_W'(STS_BASE + b));
    assign en_hit  = wr_en_i && (wr_addr_i == ADDR_W'(EN_BASE + b));

    // event set has priority over write-one-to-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q <= '0;
        en_q  <= '0;
      end else begin
        sts_q <= ((sts_q & ~(sts_hit ? wr_data_i : 8'h00)) | set_v[b*8 +: 8]) & impl;
        if (en_hit) en_q <= wr_data_i & impl;
      end
    end
    assign sts_o[b*8 +: 8] = sts_q;
    assign en_o[b*8 +: 8]  = en_q;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.tmr |=> sts_o[PM1_TMR]); // R4
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(STS_BASE) && wr_data_i[PM1_TMR] && !evt_i.tmr)
    |=> !sts_o[PM1_TMR]); // R3
  AST_PWRBTN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.pwrbtn |=> sts_o[PM1_PWRBTN]); // R11
endmodule

// File: rtl/acpi_gpe_regs.sv
module acpi_gpe_regs
  import acpi_evt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int HALF   = 2,
  parameter int BASE   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                hotplug_i,
  output logic [8*HALF-1:0]   sts_o,
  output logic [8*HALF-1:0]   en_o
);
  localparam int EN_BASE = BASE + HALF;

  logic [8*HALF-1:0] set_v;

  always_comb begin
    set_v = '0;
    set_v[GPE_HP_BIT] = hotplug_i;
  end

  for (genvar b = 0; b < HALF; b++) begin : g_lane
    logic       sts_hit, en_hit;
    logic [7:0] sts_q, en_q;
    assign sts_hit = wr_en_i && (wr_addr_i == ADDR_W'(BASE + b));
    assign en_hit  = wr_en_i && (wr_addr_i == ADDR_W'(EN_BASE + b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q <= '0;
        en_q  <= '0;
      end else begin
        sts_q <= (sts_q & ~(sts_hit ? wr_data_i : 8'h00)) | set_v[b*8 +: 8];
        if (en_hit) en_q <= wr_data_i;
      end
    end
    assign sts_o[b*8 +: 8] = sts_q;
    assign en_o[b*8 +: 8]  = en_q;
  end

  AST_HP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hotplug_i |=> sts_o[GPE_HP_BIT]); // R6
endmodule

// File: rtl/acpi_apm_ctl.sv
module acpi_apm_ctl
  import acpi_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       apm_we_i,
  input  logic [7:0] apm_cmd_i,
  input  logic       smi_cfg_i,
  output logic       sci_en_o,
  output logic       smi_o
);
  logic sci_en_q, smi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_q <= 1'b0;
      smi_q    <= 1'b0;
    end else begin
      smi_q <= apm_we_i && smi_cfg_i;
      if (apm_we_i && apm_cmd_i == APM_ACPI_ON)  sci_en_q <= 1'b1;
      if (apm_we_i && apm_cmd_i == APM_ACPI_OFF) sci_en_q <= 1'b0;
    end
  end

  assign sci_en_o = sci_en_q;
  assign smi_o    = smi_q;

  AST_APM_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_we_i && apm_cmd_i == APM_ACPI_ON) |=> sci_en_o); // R9
  AST_APM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_we_i && apm_cmd_i == APM_ACPI_OFF) |=> !sci_en_o); // R9
  AST_APM_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apm_we_i |=> $stable(sci_en_o)); // R9
  AST_SMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_we_i && smi_cfg_i) |=> smi_o); // R10
  AST_SMI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apm_we_i |=> !smi_o); // R10
endmodule

// File: rtl/acpi_sci_agg.sv
module acpi_sci_agg
  import acpi_evt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int GPE_HALF = 2,
  parameter int GPE_BASE = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        tmr_evt_i,
  input  logic        gbl_evt_i,
  input  logic        pwrbtn_evt_i,
  input  logic        rtc_evt_i,
  input  logic        hotplug_evt_i,
  input  logic        apm_we_i,
  input  logic [7:0]  apm_cmd_i,
  input  logic        smi_cfg_i,
  output logic        sci_o,
  output logic        smi_o,
  output logic        tmr_arm_o
);
  localparam int PM1_W     = 16;
  localparam int PM1_LANES = PM1_W / 8;
  localparam int STS_BASE  = 0;
  localparam int EN_BASE   = PM1_LANES;
  localparam int CTL_BASE  = 2 * PM1_LANES;
  localparam int GPE_W     = 8 * GPE_HALF;

  pm1_evt_t         evt;
  logic [PM1_W-1:0] pm1_sts, pm1_en;
  logic [GPE_W-1:0] gpe_sts, gpe_en;
  logic             sci_en;
  logic             pm1_pend, gpe_pend;

  assign evt = '{tmr: tmr_evt_i, gbl: gbl_evt_i, pwrbtn: pwrbtn_evt_i, rtc: rtc_evt_i};

  acpi_pm1_regs #(.ADDR_W(ADDR_W), .REG_W(PM1_W), .STS_BASE(STS_BASE), .EN_BASE(EN_BASE)) u_pm1 (
    .clk_i, .rst_ni,
    .wr_en_i(reg_we_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
    .evt_i(evt), .sts_o(pm1_sts), .en_o(pm1_en)
  );

  acpi_gpe_regs #(.ADDR_W(ADDR_W), .HALF(GPE_HALF), .BASE(GPE_BASE)) u_gpe (
    .clk_i, .rst_ni,
    .wr_en_i(reg_we_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
    .hotplug_i(hotplug_evt_i), .sts_o(gpe_sts), .en_o(gpe_en)
  );

  acpi_apm_ctl u_apm (
    .clk_i, .rst_ni,
    .apm_we_i, .apm_cmd_i, .smi_cfg_i,
    .sci_en_o(sci_en), .smi_o
  );

  assign pm1_pend  = |(pm1_sts & pm1_en & PM1_IMPL);
  assign gpe_pend  = gpe_sts[GPE_HP_BIT] & gpe_en[GPE_HP_BIT];
  assign sci_o     = pm1_pend | gpe_pend;
  assign tmr_arm_o = pm1_en[PM1_TMR] & ~pm1_sts[PM1_TMR];

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < PM1_LANES; b++) begin
      if (reg_addr_i == ADDR_W'(STS_BASE + b)) reg_rdata_o = pm1_sts[b*8 +: 8];
      if (reg_addr_i == ADDR_W'(EN_BASE + b))  reg_rdata_o = pm1_en[b*8 +: 8];
    end
    if (reg_addr_i == ADDR_W'(CTL_BASE)) reg_rdata_o = {7'b0, sci_en};
    for (int b = 0; b < GPE_HALF; b++) begin
      if (reg_addr_i == ADDR_W'(GPE_BASE + b))            reg_rdata_o = gpe_sts[b*8 +: 8];
      if (reg_addr_i == ADDR_W'(GPE_BASE + GPE_HALF + b)) reg_rdata_o = gpe_en[b*8 +: 8];
    end
  end

  AST_SCI_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm1_en == '0 && gpe_en == '0) |-> !sci_o); // R5
  AST_SCI_AFTER_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrbtn_evt_i && pm1_en[PM1_PWRBTN]) |=> sci_o); // R7
  AST_ARM_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_evt_i |=> !tmr_arm_o); // R8
endmodule

// File: tb/tb_acpi_sci_agg.sv
module tb_acpi_sci_agg;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic       reg_we_i = 0;
  logic [3:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0, reg_rdata_o;
  logic       tmr_evt_i = 0, gbl_evt_i = 0, pwrbtn_evt_i = 0, rtc_evt_i = 0, hotplug_evt_i = 0;
  logic       apm_we_i = 0, smi_cfg_i = 0;
  logic [7:0] apm_cmd_i = 0;
  logic       sci_o, smi_o, tmr_arm_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  acpi_sci_agg dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic rd_chk(string req, input logic [3:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk_i);
    case (which)
      0: tmr_evt_i = 1;
      1: gbl_evt_i = 1;
      2: pwrbtn_evt_i = 1;
      3: rtc_evt_i = 1;
      default: hotplug_evt_i = 1;
    endcase
    @(negedge clk_i);
    {tmr_evt_i, gbl_evt_i, pwrbtn_evt_i, rtc_evt_i, hotplug_evt_i} = '0;
  endtask

  task automatic apm(input logic [7:0] c);
    @(negedge clk_i);
    apm_we_i = 1; apm_cmd_i = c;
    @(negedge clk_i);
    apm_we_i = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 12; a++) rd_chk("R1 reg", 4'(a), 8'h00);
    chk("R1 sci", sci_o, 0);
    chk("R1 smi", smi_o, 0);
    chk("R1 arm", tmr_arm_o, 0);
  endtask

  task automatic t_impl_mask;
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    rd_chk("R2 en lo", 4'd2, 8'h21);
    rd_chk("R2 en hi", 4'd3, 8'h05);
    wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    rd_chk("R2 en lo clr", 4'd2, 8'h00);
  endtask

  task automatic t_pwrbtn;
    wr(4'd3, 8'h01);
    pulse(2);
    rd_chk("R11 pwrbtn sts", 4'd1, 8'h01);
    chk("R5 sci pwrbtn", sci_o, 1);
    wr(4'd1, 8'h00);
    rd_chk("R3 write zero keeps", 4'd1, 8'h01);
    wr(4'd1, 8'h01);
    rd_chk("R3 w1c", 4'd1, 8'h00);
    chk("R7 sci drop after clear", sci_o, 0);
  endtask

  task automatic t_rtc_gbl;
    wr(4'd3, 8'h04);
    pulse(3);
    chk("R5 sci rtc", sci_o, 1);
    wr(4'd3, 8'h00);
    chk("R5 sci rtc disabled", sci_o, 0);
    rd_chk("R3 rtc sts kept", 4'd1, 8'h04);
    wr(4'd1, 8'h04);
    pulse(1);
    chk("R5 gbl no enable", sci_o, 0);
    rd_chk("R2 gbl sts", 4'd0, 8'h20);
    wr(4'd2, 8'h20);
    chk("R5 gbl enabled", sci_o, 1);
    wr(4'd0, 8'h20); wr(4'd2, 8'h00);
    chk("R5 gbl cleared", sci_o, 0);
  endtask

  task automatic t_timer;
    wr(4'd2, 8'h01);
    chk("R8 arm when enabled", tmr_arm_o, 1);
    pulse(0);
    chk("R8 arm off when pending", tmr_arm_o, 0);
    chk("R5 sci tmr", sci_o, 1);
    // clear and new event in same cycle
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 4'd0; reg_wdata_i = 8'h01; tmr_evt_i = 1;
    @(negedge clk_i);
    reg_we_i = 0; tmr_evt_i = 0;
    rd_chk("R4 set wins", 4'd0, 8'h01);
    wr(4'd0, 8'h01);
    chk("R8 arm again", tmr_arm_o, 1);
    wr(4'd2, 8'h00);
    chk("R8 arm off disabled", tmr_arm_o, 0);
  endtask

  task automatic t_gpe;
    pulse(4);
    rd_chk("R6 hp sts", 4'd8, 8'h02);
    chk("R6 sci no gpe en", sci_o, 0);
    wr(4'd10, 8'hFD);
    chk("R6 other gpe en ignored", sci_o, 0);
    wr(4'd10, 8'h02);
    chk("R6 sci hotplug", sci_o, 1);
    wr(4'd11, 8'hA5);
    rd_chk("R6 gpe en byte3", 4'd11, 8'hA5);
    rd_chk("R6 gpe en byte2", 4'd10, 8'h02);
    wr(4'd8, 8'h02);
    rd_chk("R3 gpe w1c", 4'd8, 8'h00);
    chk("R6 sci off", sci_o, 0);
  endtask

  task automatic t_apm;
    apm(8'hF1);
    rd_chk("R9 sci_en on", 4'd4, 8'h01);
    chk("R10 no smi cfg off", smi_o, 0);
    apm(8'h55);
    rd_chk("R9 other keeps", 4'd4, 8'h01);
    apm(8'hF0);
    rd_chk("R9 sci_en off", 4'd4, 8'h00);
    apm(8'hF3);
    rd_chk("R9 near code ignored", 4'd4, 8'h00);
    smi_cfg_i = 1;
    apm(8'h12);
    chk("R10 smi pulse", smi_o, 1);
    @(negedge clk_i);
    chk("R10 smi one cycle", smi_o, 0);
    smi_cfg_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_impl_mask();
    t_pwrbtn();
    t_rtc_gbl();
    t_timer();
    t_gpe();
    t_apm();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule